// File: doc/BRIEF.md
# Serial register control port

This block is a four-wire serial slave that gives an external controller read and write access to a bank of eight-bit configuration registers. The controller drives a serial clock, an active-low select and a read/write strobe. One bidirectional data line carries the address and the write data into the block, and carries the read data back out. Every transfer is sixteen rising serial clock edges long: an eight-bit address first, then eight data bits, both sent most significant bit first.

The serial clock, data and strobe inputs are oversampled in the master clock domain through two-flop synchronisers, and rising serial edges are found there. The serial clock therefore runs at most at half the master clock rate. Raising the select asynchronously returns the transfer machine to its start state. Address bits 6 to 2 pick one of 32 registers. A parameter mask marks some registers as read-only. A read-only register reads a status input slot, and a read/write register drives a configuration output slot.

The transfer machine has four states. `S_ADDR` shifts in address bits. On the eighth edge it takes the transition to `S_RDATA` if the strobe is high, or to `S_WDATA` if it is low. `S_WDATA` shifts in eight data bits and, on the last of them, issues one write strobe and moves to `S_HOLD`. `S_RDATA` drives the selected register out bit by bit and moves to `S_HOLD` on the eighth data edge. `S_HOLD` ignores all further edges. Deasserting the select takes every state back to `S_ADDR`.

Top module: `sreg_port`

## Requirements
- R1: A transfer is 8 address bits then 8 data bits, each MSB first, sampled on rising serial clock edges. With the strobe low at the 8th edge it is a write, and the written byte appears in the register's `cfg_out` slot within 8 master cycles of the 16th edge.
- R2: The register index is address bits 6:2. Address bits 1:0 have no effect on reads or writes.
- R3: With the strobe high at the 8th edge, the register value is driven MSB first. Data bit k (k=0 is the MSB) is valid on `ser_io` from shortly after edge 8+k until edge 9+k, so the controller samples it just before edge 9+k.
- R4: Registers whose bit is set in `RO_MASK` (by default indices 24, 25, 26, 27 and 29) read back their `stat_in` slot at the time of the 8th edge. Writes to them are ignored, and their `cfg_out` slot is zero.
- R5: Addresses 0x80 to 0xFF select no register. Reads return 0x00, and writes change no `cfg_out` bit.
- R6: The block drives `ser_io` only in the data phase of a read with the select low. It releases the line after the 16th edge and whenever the select is high.
- R7: Raising the select part-way through a transfer cancels it without a write. The next transfer starts again from address bit 7.
- R8: After reset every `cfg_out` bit is zero and `ser_io` is released.
- R9: Rising edges after the 16th in the same transfer are ignored. They change neither the written register nor the read data.
- R10: A `cfg_out` slot changes only at the end of a completed write to that register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ser_clk | input | 1 | Serial clock from the controller |
| ser_cs_n | input | 1 | Active-low select; high resets the transfer machine |
| ser_rw | input | 1 | High = read, low = write |
| ser_io | inout | 1 | Bidirectional serial data |
| stat_in | input | NREG*DW | Status value for each read-only register, slot i at bits i*DW +: DW |
| cfg_out | output | NREG*DW | Stored value of each read/write register, slot i at bits i*DW +: DW |

## Verification
A rising serial edge is seen by the transfer machine three master cycles after it happens: two synchroniser stages, then the edge-detect register. Read data therefore changes three cycles after the edge, and a written byte reaches `cfg_out` four cycles after the 16th edge. The bench holds each serial clock level for four master cycles and changes its data only on falling edges. It samples read bits just before the next rising edge, eight cycles after the previous one. It checks `cfg_out` only after the select has gone high, which is at least eight cycles after the last edge. Each sample is therefore taken after the result it checks is due and before the next stimulus can move it.

// File: rtl/sreg_pkg.sv
package sreg_pkg;

    typedef enum logic [1:0] {
        S_ADDR  = 2'd0,
        S_WDATA = 2'd1,
        S_RDATA = 2'd2,
        S_HOLD  = 2'd3
    } sreg_state_e;

endpackage

// File: rtl/sreg_sync.sv
module sreg_sync #(
    parameter int W = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    logic [W-1:0] stage1;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stage1 <= '0;
            q      <= '0;
        end else begin
            stage1 <= d;
            q      <= stage1;
        end
    end

endmodule

// File: rtl/sreg_bank.sv
module sreg_bank #(
    parameter int             NREG    = 32,
    parameter int             DW      = 8,
    parameter int             IW      = 5,
    parameter logic [NREG-1:0] RO_MASK = '0
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [IW-1:0]      wr_idx,
    input  logic [DW-1:0]      wr_data,
    input  logic [IW-1:0]      rd_idx,
    input  logic [NREG*DW-1:0] stat_in,
    output logic [NREG*DW-1:0] cfg_out,
    output logic [DW-1:0]      rd_data
);

    logic [DW-1:0] slot_rd [NREG];

    for (genvar g = 0; g < NREG; g++) begin : g_slot
        if (RO_MASK[g]) begin : g_ro
            assign cfg_out[g*DW +: DW] = '0;
            assign slot_rd[g]          = stat_in[g*DW +: DW];
        end else begin : g_rw
            logic [DW-1:0] q;
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    q <= '0;
                end else if (wr_en && (wr_idx == IW'(g))) begin
                    q <= wr_data;
                end
            end
            assign cfg_out[g*DW +: DW] = q;
            assign slot_rd[g]          = q;
        end
    end

    assign rd_data = slot_rd[rd_idx];

endmodule

// File: rtl/sreg_fsm.sv
module sreg_fsm
    import sreg_pkg::*;
#(
    parameter int AW   = 8,
    parameter int DW   = 8,
    parameter int IW   = 5,
    parameter int NREG = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cs_n,
    input  logic          sclk_s,
    input  logic          sdi_s,
    input  logic          rw_s,
    input  logic [DW-1:0] rd_data,
    output logic [IW-1:0] rd_idx,
    output logic          wr_en,
    output logic [IW-1:0] wr_idx,
    output logic [DW-1:0] wr_data,
    output logic          sd_oe,
    output logic          sd_do
);

    localparam int MX = (AW > DW) ? AW : DW;
    localparam int CW = $clog2(MX);
    localparam int HW = AW - 2;
    localparam logic [CW-1:0] ALAST = CW'(AW - 1);
    localparam logic [CW-1:0] DLAST = CW'(DW - 1);

    sreg_state_e    st, st_nx;
    logic           frst_n;
    logic           sclk_d;
    logic           rise;
    logic [CW-1:0]  cnt;
    logic [AW-2:0]  addr_sr;
    logic [AW-1:0]  full_addr;
    logic [HW-1:0]  hi;
    logic           in_rng;
    logic [DW-1:0]  data_sr;
    logic [IW-1:0]  a_idx;
    logic           a_ok;

    // select high holds the transfer machine in its start state
    assign frst_n    = rst_n & ~cs_n;
    assign rise      = sclk_s & ~sclk_d;
    assign full_addr = {addr_sr, sdi_s};
    assign hi        = full_addr[AW-1:2];
    assign in_rng    = (32'(hi) < 32'(NREG));
    assign rd_idx    = hi[IW-1:0];

    // state register
    always_ff @(posedge clk or negedge frst_n) begin
        if (!frst_n) begin
            st <= S_ADDR;
        end else begin
            st <= st_nx;
        end
    end

    // next state
    always_comb begin
        st_nx = st;
        if (rise) begin
            unique case (st)
                S_ADDR:  if (cnt == ALAST) st_nx = rw_s ? S_RDATA : S_WDATA;
                S_WDATA: if (cnt == DLAST) st_nx = S_HOLD;
                S_RDATA: if (cnt == DLAST) st_nx = S_HOLD;
                S_HOLD:  st_nx = S_HOLD;
            endcase
        end
    end

    // datapath and outputs
    always_ff @(posedge clk or negedge frst_n) begin
        if (!frst_n) begin
            sclk_d  <= 1'b1;
            cnt     <= '0;
            addr_sr <= '0;
            data_sr <= '0;
            a_idx   <= '0;
            a_ok    <= 1'b0;
            wr_en   <= 1'b0;
            wr_idx  <= '0;
            wr_data <= '0;
        end else begin
            sclk_d <= sclk_s;
            wr_en  <= 1'b0;
            if (rise) begin
                unique case (st)
                    S_ADDR: begin
                        addr_sr <= full_addr[AW-2:0];
                        if (cnt == ALAST) begin
                            cnt     <= '0;
                            a_idx   <= hi[IW-1:0];
                            a_ok    <= in_rng;
                            data_sr <= in_rng ? rd_data : '0;
                        end else begin
                            cnt <= cnt + 1'b1;
                        end
                    end
                    S_WDATA: begin
                        data_sr <= {data_sr[DW-2:0], sdi_s};
                        if (cnt == DLAST) begin
                            cnt     <= '0;
                            wr_en   <= a_ok;
                            wr_idx  <= a_idx;
                            wr_data <= {data_sr[DW-2:0], sdi_s};
                        end else begin
                            cnt <= cnt + 1'b1;
                        end
                    end
                    S_RDATA: begin
                        if (cnt == DLAST) begin
                            cnt <= '0;
                        end else begin
                            cnt     <= cnt + 1'b1;
                            data_sr <= {data_sr[DW-2:0], 1'b0};
                        end
                    end
                    S_HOLD: begin
                        cnt <= cnt;
                    end
                endcase
            end
        end
    end

    assign sd_oe = (st == S_RDATA);
    assign sd_do = data_sr[DW-1];

endmodule

// File: rtl/sreg_port.sv
module sreg_port #(
    parameter int              NREG    = 32,
    parameter int              DW      = 8,
    parameter int              AW      = 8,
    parameter logic [NREG-1:0] RO_MASK = 32'h2F00_0000
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               ser_clk,
    input  logic               ser_cs_n,
    input  logic               ser_rw,
    inout  wire                ser_io,
    input  logic [NREG*DW-1:0] stat_in,
    output logic [NREG*DW-1:0] cfg_out
);

    localparam int IW = $clog2(NREG);

    logic [2:0]    sync_q;
    logic          wr_en;
    logic [IW-1:0] wr_idx;
    logic [DW-1:0] wr_data;
    logic [IW-1:0] rd_idx;
    logic [DW-1:0] rd_data;
    logic          sd_oe;
    logic          sd_do;

    sreg_sync #(.W(3)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     ({ser_clk, ser_io, ser_rw}),
        .q     (sync_q)
    );

    sreg_fsm #(.AW(AW), .DW(DW), .IW(IW), .NREG(NREG)) u_fsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .cs_n    (ser_cs_n),
        .sclk_s  (sync_q[2]),
        .sdi_s   (sync_q[1]),
        .rw_s    (sync_q[0]),
        .rd_data (rd_data),
        .rd_idx  (rd_idx),
        .wr_en   (wr_en),
        .wr_idx  (wr_idx),
        .wr_data (wr_data),
        .sd_oe   (sd_oe),
        .sd_do   (sd_do)
    );

    sreg_bank #(.NREG(NREG), .DW(DW), .IW(IW), .RO_MASK(RO_MASK)) u_bank (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_idx  (wr_idx),
        .wr_data (wr_data),
        .rd_idx  (rd_idx),
        .stat_in (stat_in),
        .cfg_out (cfg_out),
        .rd_data (rd_data)
    );

    assign ser_io = sd_oe ? sd_do : 1'bz;

endmodule

// File: rtl/sreg_port_chk.sv
module sreg_port_chk #(
    parameter int              NREG    = 32,
    parameter int              DW      = 8,
    parameter int              IW      = 5,
    parameter logic [NREG-1:0] RO_MASK = '0
) (
    input logic               clk,
    input logic               rst_n,
    input logic               ser_cs_n,
    input logic               wr_en,
    input logic [IW-1:0]      wr_idx,
    input logic               sd_oe,
    input logic [NREG*DW-1:0] cfg_out
);

    // R6: no drive while the select is high
    a_r6_no_drive_idle: assert property (@(posedge clk) disable iff (!rst_n)
        ser_cs_n |-> !sd_oe);

    // R6: a write strobe never coincides with read drive
    a_r6_strobe_not_read: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> !sd_oe);

    // R1: one strobe per completed write
    a_r1_single_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> !wr_en);

    // R4: a strobe aimed at a read-only register leaves the outputs alone
    a_r4_ro_write_dropped: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && RO_MASK[wr_idx]) |=> $stable(cfg_out));

    // R10: outputs move only after a strobe
    a_r10_cfg_needs_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(cfg_out));

endmodule

bind sreg_port sreg_port_chk #(
    .NREG    (NREG),
    .DW      (DW),
    .IW      (IW),
    .RO_MASK (RO_MASK)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .ser_cs_n (ser_cs_n),
    .wr_en    (wr_en),
    .wr_idx   (wr_idx),
    .sd_oe    (sd_oe),
    .cfg_out  (cfg_out)
);

// File: tb/sim_sreg_port.sv
`timescale 1ns/1ps
module sim_sreg_port;

    localparam int          NREG = 32;
    localparam logic [31:0] ROM  = 32'h2F00_0000;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sclk = 1'b0;
    logic cs_n = 1'b1;
    logic rw = 1'b0;
    logic tb_oe = 1'b0;
    logic tb_bit = 1'b0;
    logic [NREG*8-1:0] stat;
    wire  [NREG*8-1:0] cfg;
    wire  sio;

    int n_chk = 0;
    int n_bad = 0;
    logic [7:0] m_cfg [NREG];

    assign sio = tb_oe ? tb_bit : 1'bz;
    pullup (sio);

    always #2 clk = ~clk;

    sreg_port u0 (
        .clk      (clk),
        .rst_n    (rst_n),
        .ser_clk  (sclk),
        .ser_cs_n (cs_n),
        .ser_rw   (rw),
        .ser_io   (sio),
        .stat_in  (stat),
        .cfg_out  (cfg)
    );

    function automatic logic [7:0] sval(int i);
        return 8'(i * 11) ^ 8'hA5;
    endfunction

    task automatic wait_clk(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    // nedge rising edges with select low; select left low at return
    task automatic xfer(input logic r, input logic [7:0] a, input logic [7:0] wd,
                        input int nedge, output logic [7:0] rd);
        rd = 8'h00;
        cs_n = 1'b0;
        rw = r;
        sclk = 1'b0;
        wait_clk(4);
        for (int i = 0; i < nedge; i++) begin
            if (i < 8) begin
                tb_oe = 1'b1; tb_bit = a[7-i];
            end else if (!r && i < 16) begin
                tb_oe = 1'b1; tb_bit = wd[15-i];
            end else begin
                tb_oe = 1'b0;
            end
            wait_clk(4);
            if (r && i >= 8 && i < 16) rd[15-i] = sio;
            sclk = 1'b1;
            wait_clk(4);
            sclk = 1'b0;
        end
        tb_oe = 1'b0;
        wait_clk(4);
    endtask

    task automatic end_xfer();
        cs_n = 1'b1;
        wait_clk(8);
    endtask

    task automatic wr(input logic [7:0] a, input logic [7:0] d);
        logic [7:0] dummy;
        xfer(1'b0, a, d, 16, dummy);
        end_xfer();
    endtask

    task automatic rdreg(input logic [7:0] a, output logic [7:0] d);
        xfer(1'b1, a, 8'h00, 16, d);
        end_xfer();
    endtask

    function automatic logic [7:0] exp_rd(int i);
        return ROM[i] ? sval(i) : m_cfg[i];
    endfunction

    task automatic chk_cfg_all(string tag);
        for (int i = 0; i < NREG; i++)
            chk(tag, 32'(cfg[i*8 +: 8]), ROM[i] ? 32'h0 : 32'(m_cfg[i]));
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog act=running exp=finished");
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        logic [7:0] rv;
        for (int i = 0; i < NREG; i++) begin
            stat[i*8 +: 8] = sval(i);
            m_cfg[i] = 8'h00;
        end
        wait_clk(5);
        rst_n = 1'b1;
        wait_clk(4);

        // R8: reset state
        chk("R8 cfg after reset", 32'(cfg[31:0] | cfg[255:224]), 32'h0);
        chk_cfg_all("R8 cfg slot zero");
        chk("R8 line released", 32'(sio), 32'h1);

        // R1 R2 R4: write sweep with varying low address bits
        for (int i = 0; i < NREG; i++) begin
            wr(8'((i << 2) | (i & 3)), 8'(i * 37 + 5));
            if (!ROM[i]) m_cfg[i] = 8'(i * 37 + 5);
        end
        chk_cfg_all("R1 R4 cfg after write sweep");

        // R3 R2 R4: read sweep with different low address bits
        for (int i = 0; i < NREG; i++) begin
            rdreg(8'((i << 2) | ((i + 1) & 3)), rv);
            chk(ROM[i] ? "R4 read status slot" : "R3 R2 read back", 32'(rv), 32'(exp_rd(i)));
        end

        // R5: out of range
        wr(8'h84, 8'hFF);
        chk_cfg_all("R5 write out of range");
        rdreg(8'hC8, rv);
        chk("R5 read out of range", 32'(rv), 32'h0);

        // R6 R9: read reg 1 (0x2A, LSB 0) with extra edges; line released after
        xfer(1'b1, 8'h04, 8'h00, 18, rv);
        chk("R9 read with extra edges", 32'(rv), 32'h2A);
        chk("R6 released after data phase", 32'(sio), 32'h1);
        end_xfer();
        chk("R6 released with select high", 32'(sio), 32'h1);

        // R7: aborted transfer, then a clean write
        xfer(1'b0, 8'h0C, 8'h00, 5, rv);
        end_xfer();
        chk_cfg_all("R7 abort writes nothing");
        wr(8'h0C, 8'h5A);
        m_cfg[3] = 8'h5A;
        chk("R7 write after abort", 32'(cfg[3*8 +: 8]), 32'h5A);
        rdreg(8'h0C, rv);
        chk("R7 read after abort", 32'(rv), 32'h5A);

        // R9: extra edges during a write
        xfer(1'b0, 8'h14, 8'h3C, 20, rv);
        end_xfer();
        m_cfg[5] = 8'h3C;
        chk("R9 write with extra edges", 32'(cfg[5*8 +: 8]), 32'h3C);

        // R4: status change seen on read, write to read-only ignored
        stat[25*8 +: 8] = 8'hC3;
        wr(8'h64, 8'h11);
        chk_cfg_all("R4 read-only write ignored");
        rdreg(8'h64, rv);
        chk("R4 status follows input", 32'(rv), 32'hC3);

        // R1 R3 R10: every data value through register 10
        for (int v = 0; v < 256; v++) begin
            wr(8'h28, 8'(v));
            m_cfg[10] = 8'(v);
            chk("R1 value sweep cfg", 32'(cfg[10*8 +: 8]), 32'(v));
            chk("R10 neighbour unchanged", 32'(cfg[11*8 +: 8]), 32'(m_cfg[11]));
            if ((v % 8) == 3) begin
                rdreg(8'h28, rv);
                chk("R3 value sweep read", 32'(rv), 32'(v));
            end
        end

        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

endmodule